// File: doc/BRIEF.md
# EPROM Fast Programming Sequencer

This block is a synchronous controller that writes a byte-wide, UV-erasable memory device one location at a time. It walks a caller-chosen address window. At each location it drives the address and the expected byte from a data source, waits for the lines to settle, and gives one timed active-low pulse on the device chip-enable. It then releases the data bus and reads the byte back. A byte that does not read back correctly gets another pulse. After a fixed number of pulses without a match, the run stops and reports the failing location.

Once every location in the window has verified, the controller removes the programming voltage and then the core-supply boost, always in that order. It returns to the first address and compares every byte again at nominal supply. The run ends with a pass or fail flag, which holds until the next start. An erased device reads all ones, and a program pulse can only clear bits to zero. The controller therefore sees a byte that still reads ones as "not yet programmed" and retries it.

All timing values are parameters in nanoseconds, converted to clock cycles from a clock-frequency parameter. These are the settle time, the pulse width, the read-back delay and the supply ramp time.

Top module: `eprom_prog_seq`

## Requirements
- R1: While reset is held and while idle, chip-enable and output-enable stay high, both supply enables stay low, and busy, pass and fail are all low.
- R2: A start while idle samples the first and last address inputs and raises busy one cycle later. A start while busy is ignored, so the run keeps its original window.
- R3: The core-supply enable rises at least RAMP cycles before the programming-voltage enable. The programming-voltage enable falls at least RAMP cycles before the core-supply enable. The programming-voltage enable is never high while the core-supply enable is low.
- R4: Each program cycle first holds the address and drives the expected byte, with chip-enable and output-enable high, for at least SETTLE cycles. It then holds chip-enable low for exactly PULSE cycles, with output-enable high, both supplies on, and the expected byte on the bus.
- R5: After each pulse the bus is released and chip-enable and output-enable go low together. The read-back byte is taken exactly TDV cycles after chip-enable falls.
- R6: A mismatching read-back causes another program pulse at the same address. A match advances to the next address, and that address starts again from a pulse count of zero.
- R7: A location that verifies on its MAX_PULSES-th pulse is accepted. A location still mismatching after MAX_PULSES pulses ends the run with fail=1 and no further pulses. In that case fail_addr holds the location and fail_pulses holds MAX_PULSES.
- R8: After the last address verifies, both supplies are switched off in order (R3). Every address from first to last is then read once with both enables low. If all match, pass=1 and fail=0.
- R9: A mismatch in the final read pass ends the run at once with fail=1, fail_addr set to that address and fail_pulses=0. Later addresses are not read.
- R10: At the end of a run busy falls and both supplies are off. Pass and fail keep their values until the next accepted start, which clears them.
- R11: Addresses outside the sampled window receive no program pulse and keep their erased value of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled while idle) |
| first_addr | input | AW | First address of the window |
| last_addr | input | AW | Last address of the window |
| src_addr | output | AW | Address presented to the data source |
| src_data | input | DW | Expected byte for src_addr |
| dev_addr | output | AW | Device address lines |
| dev_data | inout | DW | Device data bus, driven only in program cycles |
| dev_ce_n | output | 1 | Device chip-enable, active low, carries the pulse |
| dev_oe_n | output | 1 | Device output-enable, active low |
| vcc_boost_en | output | 1 | Core-supply boost enable |
| vpp_en | output | 1 | Programming-voltage enable |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run completed and verified |
| fail | output | 1 | Last run failed |
| fail_addr | output | AW | Address of the failing location |
| fail_pulses | output | clog2(MAX_PULSES+1) | Pulse count at failure, zero for a final-pass failure |

## Verification
The device model holds a byte at its complement for the first TDV-1 cycles after chip-enable falls. A controller that samples early therefore reads the complement and retries forever or fails good locations. Some locations need several pulses and one needs exactly the pulse limit. This catches a controller that compares against its own driven byte instead of releasing the bus, and an off-by-one limit that rejects a byte verifying on its last allowed pulse or gives one pulse too many. A location made to differ only at nominal supply checks that the final pass stops there and reports zero pulses. A narrow window with a stray start during the run shows whether the window is re-sampled mid-run and whether locations outside it get pulsed.

// File: rtl/eprom_prog_pkg.sv
package eprom_prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_VCC_UP,
    S_VPP_UP,
    S_SETUP,
    S_PULSE,
    S_GAP,
    S_VFY,
    S_VPP_DN,
    S_VCC_DN,
    S_FV_GAP,
    S_FV_RD
  } prog_state_t;

  // Convert a time in ns to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int mhz);
    int c;
    c = (ns * mhz) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/eprom_prog_timer.sv
module eprom_prog_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          done
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R4
  timer_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/eprom_prog_bus.sv
module eprom_prog_bus #(
  parameter int DW = 8
) (
  input  logic          drv,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  inout  wire  [DW-1:0] pad
);

  assign pad   = drv ? wdata : {DW{1'bz}};
  assign rdata = pad;

endmodule

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq
  import eprom_prog_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 8,
  parameter int CLK_MHZ    = 250,
  parameter int PULSE_NS   = 50000,
  parameter int SETTLE_NS  = 100,
  parameter int TDV_NS     = 150,
  parameter int RAMP_NS    = 2000,
  parameter int MAX_PULSES = 25
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            start,
  input  logic [AW-1:0]                   first_addr,
  input  logic [AW-1:0]                   last_addr,
  output logic [AW-1:0]                   src_addr,
  input  logic [DW-1:0]                   src_data,
  output logic [AW-1:0]                   dev_addr,
  inout  wire  [DW-1:0]                   dev_data,
  output logic                            dev_ce_n,
  output logic                            dev_oe_n,
  output logic                            vcc_boost_en,
  output logic                            vpp_en,
  output logic                            busy,
  output logic                            pass,
  output logic                            fail,
  output logic [AW-1:0]                   fail_addr,
  output logic [$clog2(MAX_PULSES+1)-1:0] fail_pulses
);

  localparam int CW         = $clog2(MAX_PULSES + 1);
  localparam int PULSE_CYC  = ns_to_cyc(PULSE_NS, CLK_MHZ);
  localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_MHZ);
  localparam int TDV_CYC    = ns_to_cyc(TDV_NS, CLK_MHZ);
  localparam int RAMP_CYC   = ns_to_cyc(RAMP_NS, CLK_MHZ);
  localparam int M1         = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int M2         = (TDV_CYC > RAMP_CYC) ? TDV_CYC : RAMP_CYC;
  localparam int MAXC       = (M1 > M2) ? M1 : M2;
  localparam int TW         = $clog2(MAXC + 1);
  localparam logic [CW-1:0] CAP = CW'(MAX_PULSES);

  prog_state_t   st_q, st_d;
  logic [AW-1:0] addr_q, first_q, last_q, faddr_q;
  logic [CW-1:0] pcnt_q, fpul_q;
  logic          err_q, pass_q, fail_q, busy_q;
  logic          vcc_q, vpp_q, ce_n_q, oe_n_q, drv_q;
  logic          tload, tdone;
  logic [TW-1:0] tval;
  logic [DW-1:0] rdata;
  logic          match, at_last;

  eprom_prog_timer #(.TW(TW)) u_timer (
    .clk (clk), .rst (rst), .load (tload), .val (tval), .done (tdone)
  );

  eprom_prog_bus #(.DW(DW)) u_bus (
    .drv (drv_q), .wdata (src_data), .rdata (rdata), .pad (dev_data)
  );

  assign match   = (rdata == src_data);
  assign at_last = (addr_q == last_q);

  always_comb begin
    st_d  = st_q;
    tload = 1'b0;
    tval  = '0;
    unique case (st_q)
      S_IDLE: if (start) begin
        st_d = S_VCC_UP; tload = 1'b1; tval = TW'(RAMP_CYC - 1);
      end
      S_VCC_UP: if (tdone) begin
        st_d = S_VPP_UP; tload = 1'b1; tval = TW'(RAMP_CYC - 1);
      end
      S_VPP_UP: if (tdone) begin
        st_d = S_SETUP; tload = 1'b1; tval = TW'(SETTLE_CYC - 1);
      end
      S_SETUP: if (tdone) begin
        st_d = S_PULSE; tload = 1'b1; tval = TW'(PULSE_CYC - 1);
      end
      S_PULSE: if (tdone) st_d = S_GAP;
      S_GAP: begin
        st_d = S_VFY; tload = 1'b1; tval = TW'(TDV_CYC - 1);
      end
      S_VFY: if (tdone) begin
        tload = 1'b1;
        if ((match && at_last) || (!match && pcnt_q == CAP)) begin
          st_d = S_VPP_DN; tval = TW'(RAMP_CYC - 1);
        end else begin
          st_d = S_SETUP;  tval = TW'(SETTLE_CYC - 1);
        end
      end
      S_VPP_DN: if (tdone) begin
        st_d = S_VCC_DN; tload = 1'b1; tval = TW'(RAMP_CYC - 1);
      end
      S_VCC_DN: if (tdone) st_d = err_q ? S_IDLE : S_FV_GAP;
      S_FV_GAP: begin
        st_d = S_FV_RD; tload = 1'b1; tval = TW'(TDV_CYC - 1);
      end
      S_FV_RD: if (tdone) st_d = (!match || at_last) ? S_IDLE : S_FV_GAP;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE;  addr_q <= '0;  first_q <= '0;  last_q <= '0;
      pcnt_q <= '0;    err_q <= 1'b0; pass_q <= 1'b0; fail_q <= 1'b0;
      busy_q <= 1'b0;  faddr_q <= '0; fpul_q <= '0;
      vcc_q <= 1'b0;   vpp_q <= 1'b0; ce_n_q <= 1'b1; oe_n_q <= 1'b1;
      drv_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      busy_q <= (st_d != S_IDLE);
      vcc_q  <= st_d inside {S_VCC_UP, S_VPP_UP, S_SETUP, S_PULSE, S_GAP, S_VFY, S_VPP_DN};
      vpp_q  <= st_d inside {S_VPP_UP, S_SETUP, S_PULSE, S_GAP, S_VFY};
      ce_n_q <= !(st_d inside {S_PULSE, S_VFY, S_FV_RD});
      oe_n_q <= !(st_d inside {S_VFY, S_FV_RD});
      drv_q  <= st_d inside {S_SETUP, S_PULSE};
      case (st_q)
        S_IDLE: if (start) begin
          first_q <= first_addr; last_q <= last_addr; addr_q <= first_addr;
          pcnt_q <= '0; err_q <= 1'b0; pass_q <= 1'b0; fail_q <= 1'b0;
        end
        S_PULSE: if (tdone) pcnt_q <= pcnt_q + 1'b1;
        S_VFY: if (tdone) begin
          if (match) begin
            if (!at_last) begin
              addr_q <= addr_q + 1'b1;
              pcnt_q <= '0;
            end
          end else if (pcnt_q == CAP) begin
            err_q   <= 1'b1;
            faddr_q <= addr_q;
            fpul_q  <= pcnt_q;
          end
        end
        S_VCC_DN: if (tdone) begin
          if (err_q) fail_q <= 1'b1;
          else       addr_q <= first_q;
        end
        S_FV_RD: if (tdone) begin
          if (!match) begin
            fail_q  <= 1'b1;
            faddr_q <= addr_q;
            fpul_q  <= '0;
          end else if (at_last) begin
            pass_q <= 1'b1;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign src_addr     = addr_q;
  assign dev_addr     = addr_q;
  assign dev_ce_n     = ce_n_q;
  assign dev_oe_n     = oe_n_q;
  assign vcc_boost_en = vcc_q;
  assign vpp_en       = vpp_q;
  assign busy         = busy_q;
  assign pass         = pass_q;
  assign fail         = fail_q;
  assign fail_addr    = faddr_q;
  assign fail_pulses  = fpul_q;

  // R3
  vpp_needs_vcc_chk: assert property (@(posedge clk) disable iff (rst)
    vpp_q |-> vcc_q);

  // R3
  vcc_fall_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vcc_q) |-> !$past(vpp_q));

  // R5
  bus_release_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n_q |-> !drv_q);

  // R7
  pulse_cap_chk: assert property (@(posedge clk) disable iff (rst)
    pcnt_q <= CAP);

  // R7
  no_pulse_after_fail_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |-> !(!ce_n_q && oe_n_q));

  // R10
  status_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pass_q && fail_q));

  // R2
  window_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(first_q) && $stable(last_q)));

endmodule

// File: tb/eprom_prog_seq_tb.sv
module eprom_prog_seq_tb;

  localparam int PULSE_CYC  = 10;
  localparam int SETTLE_CYC = 5;
  localparam int TDV_CYC    = 3;
  localparam int RAMP_CYC   = 4;
  localparam int MAXP       = 25;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] first_addr = '0, last_addr = '0;
  logic [3:0] src_addr, dev_addr, fail_addr;
  logic [7:0] src_data;
  wire  [7:0] dev_data;
  logic       dev_ce_n, dev_oe_n, vcc_boost_en, vpp_en, busy, pass, fail;
  logic [4:0] fail_pulses;

  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  function automatic logic [7:0] exp_byte(input logic [3:0] a);
    return (8'(a) * 8'd29 + 8'h5A) ^ 8'h0F;
  endfunction

  assign src_data = exp_byte(src_addr);

  eprom_prog_seq #(
    .AW(4), .DW(8), .CLK_MHZ(250), .PULSE_NS(40), .SETTLE_NS(20),
    .TDV_NS(12), .RAMP_NS(16), .MAX_PULSES(MAXP)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .first_addr(first_addr),
    .last_addr(last_addr), .src_addr(src_addr), .src_data(src_data),
    .dev_addr(dev_addr), .dev_data(dev_data), .dev_ce_n(dev_ce_n),
    .dev_oe_n(dev_oe_n), .vcc_boost_en(vcc_boost_en), .vpp_en(vpp_en),
    .busy(busy), .pass(pass), .fail(fail), .fail_addr(fail_addr),
    .fail_pulses(fail_pulses)
  );

  // ---------------- device model ----------------
  logic [7:0] mem   [16];
  int         need  [16];
  logic [7:0] decay [16];
  int         nseen [16];
  logic       erase_req = 1'b0;
  int pw, rd_cnt, stab, vcc_age, vpp_off_age;
  int bad_pw, bad_settle, bad_data, bad_sup, fv_reads;
  logic [3:0] paddr, la;
  logic [7:0] pdata, ld;
  logic       vpp_prev, vcc_prev;
  logic [7:0] rd_val;

  assign rd_val   = vcc_boost_en ? mem[dev_addr] : (mem[dev_addr] ^ decay[dev_addr]);
  assign dev_data = (!dev_ce_n && !dev_oe_n)
                    ? ((rd_cnt >= TDV_CYC - 1) ? rd_val : ~rd_val) : 8'hzz;

  always @(posedge clk) begin
    if (erase_req) begin
      for (int i = 0; i < 16; i++) begin mem[i] <= 8'hFF; nseen[i] <= 0; end
      pw <= 0; rd_cnt <= 0; stab <= 0; vcc_age <= 0; vpp_off_age <= 0;
      bad_pw <= 0; bad_settle <= 0; bad_data <= 0; bad_sup <= 0; fv_reads <= 0;
      vpp_prev <= 1'b0; vcc_prev <= 1'b0; la <= '0; ld <= '0;
    end else begin
      if (!dev_ce_n && dev_oe_n) begin
        pw <= pw + 1; pdata <= dev_data; paddr <= dev_addr;
        if (pw == 0 && stab < SETTLE_CYC) bad_settle <= bad_settle + 1;
        if (!vpp_en || !vcc_boost_en) bad_sup <= bad_sup + 1;
        if (dev_data !== exp_byte(dev_addr)) bad_data <= bad_data + 1;
      end else if (pw != 0) begin
        if (pw != PULSE_CYC) bad_pw <= bad_pw + 1;
        nseen[paddr] <= nseen[paddr] + 1;
        if (nseen[paddr] + 1 >= need[paddr]) mem[paddr] <= mem[paddr] & pdata;
        pw <= 0;
      end
      if (!dev_ce_n && !dev_oe_n) begin
        rd_cnt <= rd_cnt + 1;
        if (rd_cnt == 0 && !vpp_en && !vcc_boost_en) fv_reads <= fv_reads + 1;
      end else rd_cnt <= 0;
      if (dev_ce_n && dev_oe_n && vpp_en) begin
        if (dev_addr == la && dev_data == ld) stab <= stab + 1;
        else stab <= 1;
        la <= dev_addr; ld <= dev_data;
      end else if (dev_ce_n) stab <= 0;
      vcc_age     <= vcc_boost_en ? vcc_age + 1 : 0;
      vpp_off_age <= vpp_en ? 0 : vpp_off_age + 1;
      if (vpp_en && !vcc_boost_en) bad_sup <= bad_sup + 1;
      if (vpp_en && !vpp_prev && vcc_age < RAMP_CYC) bad_sup <= bad_sup + 1;
      if (vcc_prev && !vcc_boost_en && vpp_off_age < RAMP_CYC) bad_sup <= bad_sup + 1;
      vpp_prev <= vpp_en; vcc_prev <= vcc_boost_en;
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clr_model();
    for (int i = 0; i < 16; i++) begin need[i] = 1; decay[i] = 8'h00; end
    @(negedge clk) erase_req = 1'b1;
    @(negedge clk) erase_req = 1'b0;
  endtask

  task automatic kick(input logic [3:0] f, input logic [3:0] l);
    @(negedge clk); first_addr = f; last_addr = l; start = 1'b1;
    @(negedge clk); start = 1'b0;
    // R10: a new start clears the old status
    chk(busy && !pass && !fail, "R10", "status after start", {busy, pass, fail}, 3'b100);
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (busy && n < 40000) begin @(negedge clk); n++; end
    chk(!busy, "R10", "run completes (watchdog)", busy, 0);
  endtask

  task automatic check_idle(input string req);
    chk(!busy && !vcc_boost_en && !vpp_en && dev_ce_n && dev_oe_n, req,
        "idle outputs", {busy, vcc_boost_en, vpp_en, dev_ce_n, dev_oe_n}, 5'b00011);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_idle("R1");
    chk(!pass && !fail, "R1", "status in reset", {pass, fail}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1");
  endtask

  task automatic t_basic();
    int bad;
    clr_model();
    kick(4'd0, 4'd15);
    wait_done();
    chk(pass && !fail, "R8", "full range passes", {pass, fail}, 2'b10);
    bad = 0;
    for (int a = 0; a < 16; a++) if (mem[a] != exp_byte(4'(a))) bad++;
    chk(bad == 0, "R4", "bytes programmed", bad, 0);
    bad = 0;
    for (int a = 0; a < 16; a++) if (nseen[a] != 1) bad++;
    chk(bad == 0, "R6", "one pulse per good byte", bad, 0);
    chk(bad_pw == 0, "R4", "pulse width", bad_pw, 0);
    chk(bad_settle == 0, "R4", "settle before pulse", bad_settle, 0);
    chk(bad_data == 0, "R4", "data during pulse", bad_data, 0);
    chk(bad_sup == 0, "R3", "supply ordering", bad_sup, 0);
    // R5: the model shows the complement before tDV, so a pass here means correct sampling
    chk(fv_reads == 16, "R8", "final reads at nominal supply", fv_reads, 16);
    check_idle("R10");
    repeat (10) @(negedge clk);
    chk(pass && !fail, "R10", "status holds", {pass, fail}, 2'b10);
  endtask

  task automatic t_retry();
    clr_model();
    need[5] = 3;
    need[9] = MAXP;
    kick(4'd0, 4'd15);
    wait_done();
    chk(pass && !fail, "R6", "retried bytes pass", {pass, fail}, 2'b10);
    // R5: a controller that read its own driven byte would stop at one pulse
    chk(nseen[5] == 3, "R6", "pulses at weak byte", nseen[5], 3);
    chk(nseen[6] == 1, "R6", "count restarts at next address", nseen[6], 1);
    chk(nseen[9] == MAXP, "R7", "byte verifying on last allowed pulse", nseen[9], MAXP);
    chk(bad_pw == 0 && bad_sup == 0, "R3", "timing across retries", bad_pw + bad_sup, 0);
  endtask

  task automatic t_limit();
    clr_model();
    need[7] = MAXP + 1;
    kick(4'd0, 4'd15);
    wait_done();
    chk(fail && !pass, "R7", "limit reached fails", {pass, fail}, 2'b01);
    chk(fail_addr == 4'd7, "R7", "fail_addr", fail_addr, 7);
    chk(fail_pulses == 5'(MAXP), "R7", "fail_pulses", fail_pulses, MAXP);
    chk(nseen[7] == MAXP, "R7", "pulses applied", nseen[7], MAXP);
    chk(nseen[8] == 0, "R7", "no later address pulsed", nseen[8], 0);
    chk(fv_reads == 0, "R7", "no final pass after failure", fv_reads, 0);
    chk(bad_sup == 0, "R3", "supplies ramped down in order", bad_sup, 0);
    check_idle("R10");
  endtask

  task automatic t_final();
    clr_model();
    decay[3] = 8'h10;
    kick(4'd0, 4'd7);
    wait_done();
    chk(fail && !pass, "R9", "final mismatch fails", {pass, fail}, 2'b01);
    chk(fail_addr == 4'd3, "R9", "fail_addr", fail_addr, 3);
    chk(fail_pulses == 0, "R9", "fail_pulses zero", fail_pulses, 0);
    chk(fv_reads == 4, "R9", "reads stop at mismatch", fv_reads, 4);
  endtask

  task automatic t_window();
    int bad;
    clr_model();
    kick(4'd2, 4'd4);
    repeat (30) @(negedge clk);
    first_addr = 4'd0; last_addr = 4'd15; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(pass && !fail, "R2", "window run passes", {pass, fail}, 2'b10);
    chk(nseen[2] == 1 && nseen[3] == 1 && nseen[4] == 1, "R2", "window pulsed",
        nseen[2] + nseen[3] + nseen[4], 3);
    bad = 0;
    for (int a = 0; a < 16; a++)
      if ((a < 2 || a > 4) && (nseen[a] != 0 || mem[a] != 8'hFF)) bad++;
    chk(bad == 0, "R11", "outside window untouched", bad, 0);
    chk(fv_reads == 3, "R2", "final reads follow sampled window", fv_reads, 3);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin need[i] = 1; decay[i] = 8'h00; end
    t_reset();
    t_basic();
    t_retry();
    t_limit();
    t_final();
    t_window();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule